// File: doc/BRIEF.md
# Packed-Field Population Counter

This unit returns the number of set bits in a 64-bit word. It treats the word as a row of equal-width fields. Each stage adds neighbouring fields in parallel, so the field width doubles from stage to stage (1 → 2 → 4 → 8 bits) and each field holds the count of its span. Two parameters pick how the tree is built. The first selects a subtract-based first stage, which needs only one mask. The second replaces the final shift-and-add stages with one multiply by a constant that has a 1 in the lowest bit of every byte, followed by a right shift that keeps the top byte.

Words enter through a valid/ready port and leave through a valid/ready port with a 7-bit count. The input is always registered. A register after each stage is optional. All registers share one advance condition: the pipeline moves whenever the output holds nothing or the consumer is taking it. A result that is not taken therefore freezes every stage and lowers `in_ready` in the same cycle. Upstream must hold `in_valid` and `in_data` until it sees `in_ready` high at a clock edge. Downstream sees `out_count` stay fixed for as long as `out_valid` is high and `out_ready` is low.

Top module: `popcount_swar`

## Requirements
- R1: When `out_valid` is high, `out_count` equals the number of 1 bits in the word accepted for that result, a value from 0 to 64.
- R2: An all-zero word gives a count of 0, and an all-ones word gives a count of 64.
- R3: With `FIRST_SUB` set, the first stage computes x − ((x >> 1) & 0x5555…) and gives the same counts as the add-based first stage.
- R4: With `USE_MUL` set, the final reduction is (x8 × 0x0101…01) >> 56 and gives the same counts as the chain of shift-and-add stages by 8, 16 and 32 followed by a mask of 0xff.
- R5: A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R6: With no back-pressure, a result appears a fixed number of cycles after its word is accepted. With `PIPE` set, that is 1 + the stage count: 7 for the shift-add chain and 5 for the multiply variant. With `PIPE` clear, it is 1.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_count` hold and `in_ready` is low.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.
- R9: Results leave in acceptance order, exactly one per accepted word, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_data | input | 64 | Word to count |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_count | output | 7 | Number of set bits, 0 to 64 |

## Verification
The bench drives three configurations side by side:
- the add-based shift-add chain, pipelined;
- the subtract-first multiply variant, pipelined;
- the subtract-first chain with no stage registers.

Each configuration gets the same input patterns, and each pattern separates a different class of fault:
- **All-zero and all-ones words** hit the extremes of the range. A count of 64 needs bit 6, so these words expose a lost top bit.
- **Walking-one words** show whether every bit position is counted exactly once.
- **Walking-zero words** stress carries inside each field at every stage, and reveal wrong masks or shifts.
- **Random words** under a random `out_ready` exercise stalls, hold behaviour, ordering and the fixed latency.

// File: rtl/popcount_swar_pkg.sv
`timescale 1ns/1ps
package popcount_swar_pkg;

  typedef enum int {
    K_ADD_PRE,   // mask both addends, then add
    K_SUB_PRE,   // subtract the masked, shifted word
    K_ADD_POST,  // add, then mask once
    K_ADD_RAW,   // add with no mask
    K_MUL        // multiply by byte-ones constant, keep top byte
  } stage_kind_e;

  // Repeating pattern: in every 2*sh-bit field, the low sh bits are 1.
  function automatic logic [63:0] half_mask(int sh);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = ((i % (2 * sh)) < sh);
    return m;
  endfunction

  // A 1 in the least significant bit of every byte.
  function automatic logic [63:0] byte_ones();
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = ((i % 8) == 0);
    return m;
  endfunction

  function automatic stage_kind_e kind_of(int k, bit first_sub, bit use_mul);
    if (k == 1) return first_sub ? K_SUB_PRE : K_ADD_PRE;
    if (k == 2) return K_ADD_PRE;
    if (k == 3) return K_ADD_POST;
    return use_mul ? K_MUL : K_ADD_RAW;
  endfunction

  function automatic int shift_of(int k);
    if (k == 1) return 1;
    if (k == 2) return 2;
    if (k == 3) return 4;
    return 8 << (k - 4);
  endfunction

endpackage

// File: rtl/popcount_swar_stage.sv
`timescale 1ns/1ps
module popcount_swar_stage
  import popcount_swar_pkg::*;
#(
  parameter int          W    = 64,
  parameter stage_kind_e KIND = K_ADD_RAW,
  parameter int          SH   = 8
) (
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (KIND == K_MUL) begin : g_mul
      localparam logic [63:0] K64 = byte_ones();
      localparam logic [W-1:0] KW = K64[W-1:0];
      logic [W-1:0] prod;
      assign prod = d * KW;
      assign q    = prod >> (W - 8);
    end else if (KIND == K_ADD_RAW) begin : g_raw
      assign q = d + (d >> SH);
    end else begin : g_masked
      localparam logic [63:0] M64 = half_mask(SH);
      localparam logic [W-1:0] MW = M64[W-1:0];
      if (KIND == K_ADD_PRE) begin : g_pre
        assign q = (d & MW) + ((d >> SH) & MW);
      end else if (KIND == K_SUB_PRE) begin : g_sub
        assign q = d - ((d >> SH) & MW);
      end else begin : g_post
        assign q = (d + (d >> SH)) & MW;
      end
    end
  endgenerate

endmodule

// File: rtl/popcount_swar_slot.sv
`timescale 1ns/1ps
module popcount_swar_slot #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         vin,
  input  logic [W-1:0] din,
  output logic         vout,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vout <= 1'b0;
      dout <= '0;
    end else if (en) begin
      vout <= vin;
      dout <= din;
    end
  end

endmodule

// File: rtl/popcount_swar.sv
`timescale 1ns/1ps
module popcount_swar
  import popcount_swar_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter bit PIPE      = 1'b1,
  parameter bit FIRST_SUB = 1'b0,
  parameter bit USE_MUL   = 1'b0,
  localparam int CNT_W    = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CNT_W-1:0]  out_count
);

  localparam int LOG_W = $clog2(DATA_W);
  localparam int NSTG  = USE_MUL ? 4 : LOG_W;
  localparam int LAT   = 1 + (PIPE ? NSTG : 0);

  logic              adv;
  logic [DATA_W-1:0] sd [NSTG+1];
  logic              sv [NSTG+1];
  logic [DATA_W-1:0] cq [NSTG+1];

  // One shared advance condition stalls every register together.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign cq[0]    = '0;

  popcount_swar_slot #(.W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .vin(in_valid), .din(in_data),
    .vout(sv[0]), .dout(sd[0])
  );

  for (genvar k = 1; k <= NSTG; k++) begin : g_stg
    popcount_swar_stage #(
      .W(DATA_W),
      .KIND(kind_of(k, FIRST_SUB, USE_MUL)),
      .SH(shift_of(k))
    ) u_op (
      .d(sd[k-1]),
      .q(cq[k])
    );
    if (PIPE) begin : g_reg
      popcount_swar_slot #(.W(DATA_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .en(adv),
        .vin(sv[k-1]), .din(cq[k]),
        .vout(sv[k]), .dout(sd[k])
      );
    end else begin : g_wire
      assign sv[k] = sv[k-1];
      assign sd[k] = cq[k];
    end
  end

  assign out_valid = sv[NSTG];
  assign out_count = CNT_W'(sd[NSTG] & DATA_W'(8'hff));

  // Kept for the bound checker.
  localparam int LAT_CYC = LAT;

endmodule

// File: rtl/popcount_swar_chk.sv
`timescale 1ns/1ps
module popcount_swar_chk #(
  parameter int W     = 64,
  parameter int LAT   = 7,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CNT_W-1:0] out_count
);

  logic [7:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + 8'(in_valid && in_ready) - 8'(out_valid && out_ready);
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_count));

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_count <= CNT_W'(W));

  assert_inflight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 8'(LAT));

  assert_no_phantom_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ != 8'd0);

endmodule

bind popcount_swar popcount_swar_chk #(
  .W(DATA_W), .LAT(LAT_CYC), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_count(out_count)
);

// File: tb/popcount_swar_tb_top.sv
`timescale 1ns/1ps
module popcount_swar_tb_top;

  localparam int NDUT = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        in_valid;
  logic        out_ready;
  logic [63:0] in_data;
  logic [NDUT-1:0] ir;
  logic [NDUT-1:0] ov;
  logic [6:0]  oc [NDUT];

  popcount_swar #(.DATA_W(64), .PIPE(1'b1), .FIRST_SUB(1'b0), .USE_MUL(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[0]), .in_data(in_data),
    .out_valid(ov[0]), .out_ready(out_ready), .out_count(oc[0]));

  popcount_swar #(.DATA_W(64), .PIPE(1'b1), .FIRST_SUB(1'b1), .USE_MUL(1'b1)) dut_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[1]), .in_data(in_data),
    .out_valid(ov[1]), .out_ready(out_ready), .out_count(oc[1]));

  popcount_swar #(.DATA_W(64), .PIPE(1'b0), .FIRST_SUB(1'b1), .USE_MUL(1'b0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[2]), .in_data(in_data),
    .out_valid(ov[2]), .out_ready(out_ready), .out_count(oc[2]));

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;
  bit bp_on = 1'b0;

  logic [6:0] exp_mem [NDUT][64];
  int         acc_cyc [NDUT][64];
  int         wr [NDUT];
  int         rd [NDUT];
  logic       hold_prev [NDUT];
  logic [6:0] cnt_prev  [NDUT];

  function automatic int lat_of(int j);
    if (j == 0) return 7;
    if (j == 1) return 5;
    return 1;
  endfunction

  function automatic string tag_of(int j);
    if (j == 0) return "R1";
    if (j == 1) return "R3 R4";
    return "R3 R1";
  endfunction

  function automatic logic [6:0] ref_count(logic [63:0] w);
    logic [6:0] c = '0;
    for (int i = 0; i < 64; i++) c = c + 7'(w[i]);
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(logic v, logic [63:0] d, logic r);
    @(negedge clk);
    in_valid  = v;
    in_data   = d;
    out_ready = r;
    #5;
    cyc++;
    for (int j = 0; j < NDUT; j++) begin
      if (hold_prev[j])
        chk(ov[j] && oc[j] == cnt_prev[j], "R7", int'(oc[j]), int'(cnt_prev[j]));
      chk(ir[j] == (!ov[j] || out_ready), "R5", int'(ir[j]), int'(!ov[j] || out_ready));
      if (ov[j] && out_ready) begin
        if (rd[j] == wr[j]) begin
          chk(1'b0, "R9", 1, 0);
        end else begin
          logic [6:0] e;
          e = exp_mem[j][rd[j] % 64];
          chk(oc[j] == e,
              (e == 7'd0 || e == 7'd64) ? {"R2 ", tag_of(j)} : tag_of(j),
              int'(oc[j]), int'(e));
          if (!bp_on)
            chk(cyc - acc_cyc[j][rd[j] % 64] == lat_of(j), "R6",
                cyc - acc_cyc[j][rd[j] % 64], lat_of(j));
          rd[j]++;
        end
      end
      if (v && ir[j]) begin
        exp_mem[j][wr[j] % 64] = ref_count(d);
        acc_cyc[j][wr[j] % 64] = cyc;
        wr[j]++;
      end
      hold_prev[j] = ov[j] && !out_ready;
      cnt_prev[j]  = oc[j];
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NDUT; j++) begin
      wr[j] = 0; rd[j] = 0; hold_prev[j] = 1'b0; cnt_prev[j] = '0;
    end
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    for (int j = 0; j < NDUT; j++) begin
      chk(!ov[j], "R8", int'(ov[j]), 0);
      chk(ir[j], "R8", int'(ir[j]), 1);
    end

    // Extremes (R2), walking one and walking zero (R1), no back-pressure (R6)
    step(1'b1, 64'd0, 1'b1);
    step(1'b1, ~64'd0, 1'b1);
    step(1'b0, 64'd0, 1'b1);
    for (int i = 0; i < 64; i++) step(1'b1, 64'd1 << i, 1'b1);
    for (int i = 0; i < 64; i++) step(1'b1, ~(64'd1 << i), 1'b1);
    for (int i = 0; i < 64; i++) step(1'b1, (64'd1 << i) - 64'd1, 1'b1);
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, {$urandom, $urandom}, 1'b1);
    repeat (10) step(1'b0, 64'd0, 1'b1);

    // Random back-pressure: R7, R9
    bp_on = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      if (($urandom % 8) == 0) w = (($urandom % 2) == 0) ? 64'd0 : ~64'd0;
      step(($urandom % 3) != 0, w, ($urandom % 3) != 0);
    end
    repeat (20) step(1'b0, 64'd0, 1'b1);
    for (int j = 0; j < NDUT; j++) chk(rd[j] == wr[j], "R9", rd[j], wr[j]);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule